// File: doc/BRIEF.md
# Counter-Driven Key Matrix Scanner

This block reads a 64-key switch matrix on an external front panel through only three wires. The panel carries two cascaded 4-bit ripple counters. The low three bits of the first counter pick the column that is routed to a single sense line. The low three bits of the second counter pick the row that is pulled to ground. The block never drives an address. It produces a slow scan clock that steps the panel counter and a reset line that clears it. It keeps an internal copy of the counter position, so it always knows which key the sense line is reporting.

After power-up the block holds the panel counter in reset. It then releases the counter and starts toggling the scan clock. The counter advances on each falling edge of the scan clock. The block samples the synchronised sense line at the end of each low phase. Each column appears twice within a row, because the first counter stage is four bits wide, so only the visit with bit 3 of that stage at zero is used. A full frame is 128 scan clocks. At the end of each frame, every key's raw reading goes through a per-key consecutive-frame filter. The filtered 64-bit vector is then published with a one-cycle valid strobe.

Top module: `key_matrix_scanner`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `keys_o` is all zero, `keys_valid_o` is 0, `panel_rst_o` is 1 and `scan_clk_o` is 0.
- R2: After `rst_n` is released, `panel_rst_o` stays high for exactly 2*HALF_PERIOD clock cycles. It then goes low and never rises again until the next `rst_n`.
- R3: Once `panel_rst_o` is low, `scan_clk_o` starts low. It alternates between low and high phases of exactly HALF_PERIOD clock cycles each.
- R4: `scan_clk_o` is low whenever `panel_rst_o` is high.
- R5: Bit index row*8+col of `keys_o` reports the key at column col and row row. Here col is bits [2:0] of the first panel counter stage and row is bits [2:0] of the second stage. The first stage counts falling edges of `scan_clk_o`. The second stage advances when the first stage wraps from 15 to 0.
- R6: `sense_i` is active low: a 0 read for a key means pressed. In `keys_o`, a 1 means pressed and a 0 means released.
- R7: `keys_valid_o` is a single-cycle pulse, raised once per frame of 128 scan clocks. Consecutive pulses are exactly 256*HALF_PERIOD clock cycles apart.
- R8: A key is reported pressed only after DEBOUNCE_FRAMES consecutive frames read it pressed. It is reported released only after DEBOUNCE_FRAMES consecutive frames read it released. A shorter run of opposite readings leaves its bit unchanged.
- R9: `keys_o` changes only in a cycle in which `keys_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_clk_o | output | 1 | Scan clock to the panel counter; the counter advances on falling edges |
| panel_rst_o | output | 1 | Active-high clear for both panel counter stages |
| sense_i | input | 1 | Selected column level from the panel, low when the addressed key is pressed |
| keys_o | output | 64 | Filtered key vector, bit row*8+col, 1 = pressed |
| keys_valid_o | output | 1 | One-cycle strobe marking a freshly published key vector |

## Verification
The bound checker watches the port timing on every cycle. It checks that the scan clock stays parked during panel reset, that the panel reset never comes back, and that each scan-clock phase is exactly HALF_PERIOD cycles long. It also checks that the valid strobe lasts one cycle and recurs at a fixed frame spacing, and that the key vector moves only with the strobe. Whether the internal position copy matches the external counter cannot be seen from timing alone. The bench shows it by modelling the two cascaded counters and multiplexers, then comparing the published vectors against single-key corner patterns, full-matrix patterns and random patterns. Whether the filter rejects short bursts and accepts long runs also rests on the bench's frame-by-frame model.

// File: rtl/kms_pkg.sv
// kms_pkg: shared constants, types and index helpers for the key matrix
// scanner. Assumes the panel holds two cascaded 4-bit counters whose low
// three bits address an 8x8 matrix.
package kms_pkg;

    localparam int STAGE_W   = 4;                   // width of one panel counter stage
    localparam int SEL_W     = 3;                   // stage bits used as a mux select
    localparam int N_COLS    = 1 << SEL_W;
    localparam int N_ROWS    = 1 << SEL_W;
    localparam int N_KEYS    = N_COLS * N_ROWS;
    localparam int KEY_IDX_W = $clog2(N_KEYS);
    localparam int POS_W     = 2 * STAGE_W;         // full mirrored counter width
    localparam int FRAME_SCK = 1 << (STAGE_W + SEL_W); // scan clocks per frame

    typedef enum logic [0:0] {
        PH_PANEL_RST = 1'b0,
        PH_SCAN      = 1'b1
    } scan_phase_e;

    // Key index for a counter position: row bits above column bits.
    function automatic logic [KEY_IDX_W-1:0] key_index(input logic [POS_W-1:0] pos);
        return {pos[STAGE_W+SEL_W-1:STAGE_W], pos[SEL_W-1:0]};
    endfunction

    // Only the first of the two visits a column gets per row is used.
    function automatic logic primary_visit(input logic [POS_W-1:0] pos);
        return !pos[STAGE_W-1];
    endfunction

endpackage

// File: rtl/kms_scan_timer.sv
// kms_scan_timer: divides the system clock into the panel scan clock.
// While run is low the scan clock is parked low and the divider is cleared.
// sample_stb marks the last cycle of each low phase; fall_stb marks the
// cycle whose clock edge drives the scan clock low.
// Assumes HALF_PERIOD >= 3 so the sense synchroniser settles in time.
module kms_scan_timer #(
    parameter int HALF_PERIOD = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic sample_stb,
    output logic fall_stb
);

    localparam int DIV_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_PERIOD - 1);

    logic [DIV_W-1:0] div_q;
    logic             phase_end;

    assign phase_end  = run && (div_q == DIV_LAST);
    assign sample_stb = phase_end && !sck;
    assign fall_stb   = phase_end && sck;

    // Count out each half period and toggle the scan clock at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            sck   <= 1'b0;
        end else if (phase_end) begin
            div_q <= '0;
            sck   <= !sck;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/kms_sense_sync.sv
// kms_sense_sync: multi-flop synchroniser for the asynchronous panel sense
// line. Resets to the idle (high) level so no key looks pressed at start.
module kms_sense_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] shift_q;

    // Shift the raw sense level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '1;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], d};
        end
    end

    assign q = shift_q[STAGES-1];

endmodule

// File: rtl/kms_pos_tracker.sv
// kms_pos_tracker: mirrors the external two-stage ripple counter and
// collects one raw reading per key into a frame vector. It assumes that the
// panel counter was cleared while run was low and that it counts each
// falling scan-clock edge. frame_done pulses the cycle after the last key
// of a frame has been stored.
module kms_pos_tracker
    import kms_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              sample_stb,
    input  logic              fall_stb,
    input  logic              sense_sync,
    output logic [N_KEYS-1:0] raw_pressed,
    output logic              frame_done
);

    logic [POS_W-1:0]     pos_q;
    logic [KEY_IDX_W-1:0] idx;
    logic                 take;

    assign idx  = key_index(pos_q);
    assign take = sample_stb && primary_visit(pos_q);

    // Follow the panel counter: cleared with it, stepped on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pos_q <= '0;
        end else if (fall_stb) begin
            pos_q <= pos_q + 1'b1;
        end
    end

    // Store the inverted (active-low) sense level for the addressed key.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_pressed <= '0;
            frame_done  <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (take) begin
                raw_pressed[idx] <= !sense_sync;
                frame_done       <= (idx == KEY_IDX_W'(N_KEYS - 1));
            end
        end
    end

endmodule

// File: rtl/kms_debounce.sv
// kms_debounce: per-key consecutive-frame filter. On each frame_done a key
// whose raw reading differs from its reported state advances a run counter;
// after DEBOUNCE_FRAMES such frames in a row the state flips. A matching
// reading clears the counter. Assumes DEBOUNCE_FRAMES >= 1.
module kms_debounce
    import kms_pkg::*;
#(
    parameter int DEBOUNCE_FRAMES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_done,
    input  logic [N_KEYS-1:0] raw_pressed,
    output logic [N_KEYS-1:0] keys
);

    localparam int CNT_W = (DEBOUNCE_FRAMES > 1) ? $clog2(DEBOUNCE_FRAMES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEBOUNCE_FRAMES - 1);

    for (genvar k = 0; k < N_KEYS; k++) begin : g_key
        logic             state_q;
        logic [CNT_W-1:0] run_q;

        // Track how long this key has disagreed with its reported state.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q <= 1'b0;
                run_q   <= '0;
            end else if (frame_done) begin
                if (raw_pressed[k] == state_q) begin
                    run_q <= '0;
                end else if (run_q == CNT_LAST) begin
                    state_q <= raw_pressed[k];
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end

        assign keys[k] = state_q;
    end

endmodule

// File: rtl/key_matrix_scanner.sv
// key_matrix_scanner: top of the panel key scanner. It holds the panel
// counter in reset for 2*HALF_PERIOD cycles after rst_n, then runs the scan
// clock. It samples one key per primary visit and publishes the filtered
// vector with a one-cycle strobe per frame. It assumes the panel counter
// clears on panel_rst_o high and counts falling scan-clock edges.
module key_matrix_scanner
    import kms_pkg::*;
#(
    parameter int HALF_PERIOD     = 400,
    parameter int DEBOUNCE_FRAMES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              scan_clk_o,
    output logic              panel_rst_o,
    input  logic              sense_i,
    output logic [N_KEYS-1:0] keys_o,
    output logic              keys_valid_o
);

    localparam int RST_HOLD = 2 * HALF_PERIOD;
    localparam int RST_W    = $clog2(RST_HOLD + 1);

    scan_phase_e       phase_q;
    logic [RST_W-1:0]  rst_cnt_q;
    logic              run;
    logic              sample_stb;
    logic              fall_stb;
    logic              sense_sync;
    logic [N_KEYS-1:0] raw_pressed;
    logic              frame_done;

    assign run = (phase_q == PH_SCAN);

    // Hold the panel counter cleared for a fixed time, then start scanning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_PANEL_RST;
            rst_cnt_q   <= '0;
            panel_rst_o <= 1'b1;
        end else if (phase_q == PH_PANEL_RST) begin
            if (rst_cnt_q == RST_W'(RST_HOLD)) begin
                phase_q     <= PH_SCAN;
                panel_rst_o <= 1'b0;
            end else begin
                rst_cnt_q <= rst_cnt_q + 1'b1;
            end
        end
    end

    kms_scan_timer #(
        .HALF_PERIOD(HALF_PERIOD)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .sck       (scan_clk_o),
        .sample_stb(sample_stb),
        .fall_stb  (fall_stb)
    );

    kms_sense_sync #(
        .STAGES(2)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sense_i),
        .q    (sense_sync)
    );

    kms_pos_tracker u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .sample_stb (sample_stb),
        .fall_stb   (fall_stb),
        .sense_sync (sense_sync),
        .raw_pressed(raw_pressed),
        .frame_done (frame_done)
    );

    kms_debounce #(
        .DEBOUNCE_FRAMES(DEBOUNCE_FRAMES)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .raw_pressed(raw_pressed),
        .keys       (keys_o)
    );

    // Strobe valid in the same cycle the filtered vector is updated.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            keys_valid_o <= 1'b0;
        end else begin
            keys_valid_o <= frame_done;
        end
    end

endmodule

// File: rtl/kms_checker.sv
// kms_checker: port-level timing properties of key_matrix_scanner, bound
// to every instance of it. Phase and frame lengths are measured with
// counters rather than long $past chains.
module kms_checker
    import kms_pkg::*;
#(
    parameter int HALF_PERIOD = 400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_clk_o,
    input logic              panel_rst_o,
    input logic [N_KEYS-1:0] keys_o,
    input logic              keys_valid_o
);

    localparam int FRAME_CYC = 2 * HALF_PERIOD * FRAME_SCK;
    localparam int PH_W      = $clog2(HALF_PERIOD + 2);
    localparam int GAP_W     = $clog2(FRAME_CYC + 2);
    localparam logic [PH_W-1:0]  PH_MAX  = '1;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic              sck_prev_q;
    logic              toggled;
    logic [PH_W-1:0]   since_q;
    logic [GAP_W-1:0]  gap_q;
    logic              seen_q;

    assign toggled = (scan_clk_o != sck_prev_q);

    // Measure cycles since the last scan-clock edge or panel release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b0;
            since_q    <= '0;
        end else begin
            sck_prev_q <= scan_clk_o;
            if (panel_rst_o)        since_q <= '0;
            else if (toggled)       since_q <= PH_W'(1);
            else if (since_q != PH_MAX) since_q <= since_q + 1'b1;
        end
    end

    // Measure cycles since the previous valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (keys_valid_o) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else if (gap_q != GAP_MAX) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    // R4
    sck_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        panel_rst_o |-> !scan_clk_o);

    // R2
    panel_rst_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(panel_rst_o) |-> !panel_rst_o);

    // R3
    sck_phase_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (toggled && !panel_rst_o) |-> (since_q == PH_W'(HALF_PERIOD)));

    // R3
    sck_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !panel_rst_o |-> (since_q <= PH_W'(HALF_PERIOD)));

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        keys_valid_o |=> !keys_valid_o);

    // R7
    frame_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (keys_valid_o && seen_q) |-> (gap_q == GAP_W'(FRAME_CYC)));

    // R9
    keys_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (keys_o != $past(keys_o)) |-> keys_valid_o);

endmodule

bind key_matrix_scanner kms_checker #(
    .HALF_PERIOD(HALF_PERIOD)
) u_kms_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_clk_o  (scan_clk_o),
    .panel_rst_o (panel_rst_o),
    .keys_o      (keys_o),
    .keys_valid_o(keys_valid_o)
);

// File: tb/tb_key_matrix_scanner.sv
// Bench: models the panel as two cascaded 4-bit counters feeding an 8x8
// key matrix, and checks the published vectors against a frame-level
// filter model computed from the requirements.
module tb_key_matrix_scanner;

    localparam int HALF  = 4;
    localparam int DEB   = 3;
    localparam int FRAME = 256 * HALF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_clk_o;
    logic        panel_rst_o;
    logic        sense_i;
    logic [63:0] keys_o;
    logic        keys_valid_o;

    logic [63:0] cur_pat = '0;
    logic [3:0]  stage_a = '0;
    logic [3:0]  stage_b = '0;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int last_valid = -1;
    int r9_bad = 0;
    logic [63:0] prev_keys = '0;

    logic [63:0] exp_state = '0;
    int          exp_run[64];

    always #2 clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Panel model: stage_a counts falling scan-clock edges, stage_b counts its wraps.
    always @(negedge scan_clk_o or posedge panel_rst_o) begin
        if (panel_rst_o) begin
            stage_a <= '0;
            stage_b <= '0;
        end else begin
            stage_a <= stage_a + 4'd1;
            if (stage_a == 4'hF) stage_b <= stage_b + 4'd1;
        end
    end

    // Selected column goes low only if its key on the grounded row is pressed.
    assign sense_i = !cur_pat[{stage_b[2:0], stage_a[2:0]}];

    key_matrix_scanner #(
        .HALF_PERIOD    (HALF),
        .DEBOUNCE_FRAMES(DEB)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_clk_o  (scan_clk_o),
        .panel_rst_o (panel_rst_o),
        .sense_i     (sense_i),
        .keys_o      (keys_o),
        .keys_valid_o(keys_valid_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Frame-level filter model (R8).
    task automatic model_frame(input logic [63:0] pat);
        for (int k = 0; k < 64; k++) begin
            if (pat[k] == exp_state[k]) begin
                exp_run[k] = 0;
            end else if (exp_run[k] == DEB - 1) begin
                exp_state[k] = pat[k];
                exp_run[k] = 0;
            end else begin
                exp_run[k]++;
            end
        end
    endtask

    // Wait for one frame strobe and check spacing, width and vector.
    task automatic frame_step(input string req);
        while (!keys_valid_o) @(negedge clk);
        if (last_valid >= 0) check("R7 spacing", 64'(cyc - last_valid), 64'(FRAME));
        last_valid = cyc;
        model_frame(cur_pat);
        check(req, keys_o, exp_state);
        @(negedge clk);
        check("R7 width", 64'(keys_valid_o), 64'd0);
    endtask

    task automatic hold(input logic [63:0] pat, input int n, input string req);
        cur_pat = pat;
        for (int i = 0; i < n; i++) frame_step(req);
    endtask

    // R9 monitor: the vector may move only with the strobe.
    always @(negedge clk) begin
        if (rst_n) begin
            if (keys_o !== prev_keys && !keys_valid_o) r9_bad++;
            prev_keys <= keys_o;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        logic [63:0] rp;
        for (int k = 0; k < 64; k++) exp_run[k] = 0;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 keys", keys_o, 64'd0);
        check("R1 valid", 64'(keys_valid_o), 64'd0);
        check("R1 panel_rst", 64'(panel_rst_o), 64'd1);
        check("R1 sck", 64'(scan_clk_o), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {keys_o[62:0], keys_valid_o}, 64'd0);
        // R2 / R4: panel reset hold length with scan clock parked
        n = 0;
        while (panel_rst_o) begin
            if (scan_clk_o) r9_bad = r9_bad + 1000;
            n++;
            @(negedge clk);
        end
        check("R2 hold", 64'(n), 64'(2 * HALF));
        check("R4 sck parked", 64'(r9_bad >= 1000), 64'd0);
        // R3: first six scan-clock phases
        for (int p = 0; p < 6; p++) begin
            logic lvl;
            lvl = scan_clk_o;
            if (p == 0) check("R3 starts low", 64'(lvl), 64'd0);
            n = 0;
            while (scan_clk_o == lvl) begin
                n++;
                @(negedge clk);
            end
            check("R3 phase", 64'(n), 64'(HALF));
        end
        // Idle panel
        hold(64'd0, 2, "R6 idle");
        // R5 / R8: single key at index 0, appears only on the third frame
        hold(64'd1, 2, "R8 pre-threshold");
        check("R8 key0 not yet", keys_o, 64'd0);
        hold(64'd1, 1, "R5 key0");
        check("R5 key0", keys_o, 64'd1);
        hold(64'd0, 3, "R8 release");
        check("R8 key0 released", keys_o, 64'd0);
        // R5: far corner and row 1 keys
        hold(64'd1 << 63, 3, "R5 key63");
        check("R5 key63", keys_o, 64'd1 << 63);
        hold((64'd1 << 9) | (64'd1 << 14), 4, "R5 row1");
        check("R5 row1 col1 col6", keys_o, (64'd1 << 9) | (64'd1 << 14));
        hold(64'd0, 3, "R8 clear");
        // R8: two-frame burst must be filtered out
        hold(64'd1 << 20, 2, "R8 burst");
        hold(64'd0, 2, "R8 burst");
        check("R8 burst ignored", keys_o, 64'd0);
        // R6: whole matrix pressed then released
        hold('1, 3, "R6 all");
        check("R6 all pressed", keys_o, '1);
        hold(64'd0, 3, "R6 none");
        check("R6 all released", keys_o, 64'd0);
        // R8 random patterns with random hold lengths
        for (int r = 0; r < 14; r++) begin
            rp = {$urandom(), $urandom()};
            if (r % 2 == 0) rp = rp & {$urandom(), $urandom()};
            hold(rp, int'($urandom_range(1, 4)), "R8 random");
        end
        hold(64'd0, 3, "R8 final");
        check("R9 keys move only with strobe", 64'(r9_bad), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule